// File: doc/BRIEF.md
# Bridge Recirculation Gate Controller

This block drives the four switches of one H-bridge: the high-side switch and the low-side switch of leg A, and the same pair for leg B. It takes the PWM phase (drive, fast decay or slow decay), the current direction, a bridge enable and a two-bit recirculation policy. From these it decides which switches conduct. During the drive phase it closes one diagonal, which sets the current direction. During decay it either rectifies through the switches or opens them, depending on the policy. Two detector inputs can also stop rectification early: one flags that the load current has fallen to zero, the other flags that the reverse current has hit its limit.

The four gate enables come from registers. Each leg passes through a crossover guard, so a switch cannot close until its leg partner has been open for a set number of clock cycles. Once a detector has stopped rectification, the stop holds for the rest of that decay interval. It is released only when the next drive phase starts with the bridge enabled.

Top module: `srect_gate_ctrl`

## Requirements
- R1: The gate outputs are registered, and a new input pattern reaches them at the first rising clock edge, unless a crossover gap delays it. In the drive phase (`pwm_state`=0) with `bridge_en`=1, `phase`=1 closes `src_a` and `snk_b`, and `phase`=0 closes `src_b` and `snk_a`.
- R2: In fast decay (`pwm_state`=1) with `bridge_en`=1, and with policy active (`rect_mode`=0) or passive (`rect_mode`=1) and no stop in force, the block closes the diagonal opposite to the drive diagonal for the current `phase`.
- R3: In slow decay (`pwm_state`=2 or 3), both low-side switches close. With `bridge_en`=0 and any `pwm_state`, the bridge recirculates exactly as in slow decay.
- R4: With policy none (`rect_mode`=2), every switch stays open during decay.
- R5: With policy active, `zero_det`=1 during decay opens every switch. `zero_det` has no effect in the drive phase, and it has no effect under the other policies.
- R6: With policy passive, `rev_lim_det`=1 during decay opens every switch. `rev_lim_det` has no effect in the drive phase, and it has no effect under the other policies.
- R7: With policy low-side-only (`rect_mode`=3), the high-side switches never close during decay. In fast decay only the low-side switch of the opposite diagonal closes, in slow decay both low-side switches close, and both detectors are ignored.
- R8: After a switch opens, its leg partner may close no earlier than `DEAD_CYC` rising edges later (default 2). Within a leg, the two switches are never closed together.
- R9: While `rst_n` is low, all four outputs are low.
- R10: A stop set by a detector holds through later decay cycles, through changes between fast and slow decay, and through `bridge_en`=0. It clears only when the drive phase begins with `bridge_en`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwm_state | input | 2 | 0 drive, 1 fast decay, 2 or 3 slow decay |
| phase | input | 1 | Current direction: 1 runs A to B |
| bridge_en | input | 1 | 0 forces recirculation |
| rect_mode | input | 2 | 0 active, 1 passive, 2 none, 3 low-side-only |
| zero_det | input | 1 | Load current has reached zero |
| rev_lim_det | input | 1 | Reverse current has reached its limit |
| src_a | output | 1 | High-side switch, leg A |
| src_b | output | 1 | High-side switch, leg B |
| snk_a | output | 1 | Low-side switch, leg A |
| snk_b | output | 1 | Low-side switch, leg B |

## Verification
The assertions check four things on every cycle. No leg ever closes both of its switches at once. A switch closes only after its partner has been open for the full gap. Under policy none and under low-side-only, the forbidden switches stay open after any decay cycle. An active stop leaves all four gates open on the next edge. Only the bench scenarios can show the rest: the exact switch pattern for each phase and direction, the detectors being ignored under the wrong policy or in the drive phase, and a stop surviving several decay changes and then clearing on the next drive phase.

// File: rtl/srect_pkg.sv
package srect_pkg;

  typedef enum logic [1:0] {
    PWM_ON       = 2'd0,
    PWM_FAST     = 2'd1,
    PWM_SLOW     = 2'd2,
    PWM_SLOW_ALT = 2'd3
  } pwm_state_e;

  typedef enum logic [1:0] {
    RECT_ACTIVE   = 2'd0,
    RECT_PASSIVE  = 2'd1,
    RECT_NONE     = 2'd2,
    RECT_LOW_ONLY = 2'd3
  } rect_mode_e;

  // bit 0 = leg A, bit 1 = leg B
  typedef struct packed {
    logic [1:0] hi;
    logic [1:0] lo;
  } gate_req_t;

  // drive diagonal: fwd closes high A with low B
  function automatic gate_req_t drive_pair(input logic fwd);
    gate_req_t r;
    r.hi = fwd ? 2'b01 : 2'b10;
    r.lo = fwd ? 2'b10 : 2'b01;
    return r;
  endfunction

  function automatic gate_req_t fast_pair(input logic fwd);
    return drive_pair(!fwd);
  endfunction

  function automatic gate_req_t slow_pair();
    gate_req_t r;
    r.hi = 2'b00;
    r.lo = 2'b11;
    return r;
  endfunction

  function automatic gate_req_t low_side_only(input gate_req_t r_in);
    gate_req_t r;
    r.hi = 2'b00;
    r.lo = r_in.lo;
    return r;
  endfunction

  function automatic logic stop_event(input rect_mode_e m, input logic zd,
                                      input logic rl);
    return (m == RECT_ACTIVE && zd) || (m == RECT_PASSIVE && rl);
  endfunction

endpackage

// File: rtl/srect_cutoff.sv
module srect_cutoff
  import srect_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       bridge_on,
  input  rect_mode_e mode,
  input  logic       zero_det,
  input  logic       rev_lim_det,
  output logic       cut_now
);
  logic cut_q;
  logic trig;

  assign trig    = !bridge_on && stop_event(mode, zero_det, rev_lim_det);
  assign cut_now = !bridge_on && (cut_q || trig);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)         cut_q <= 1'b0;
    else if (bridge_on) cut_q <= 1'b0;
    else if (trig)      cut_q <= 1'b1;
  end

  // R10: a latched stop survives every cycle that is not a drive phase
  assert_cut_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (cut_q && !bridge_on) |=> cut_q);
endmodule

// File: rtl/srect_pattern.sv
module srect_pattern
  import srect_pkg::*;
(
  input  pwm_state_e state,
  input  logic       phase,
  input  logic       bridge_en,
  input  logic       bridge_on,
  input  rect_mode_e mode,
  input  logic       cut_now,
  output gate_req_t  req
);
  gate_req_t decay_base;

  always_comb begin
    decay_base = (bridge_en && state == PWM_FAST) ? fast_pair(phase) : slow_pair();
    if (bridge_on) begin
      req = drive_pair(phase);
    end else begin
      unique case (mode)
        RECT_NONE:     req = '0;
        RECT_LOW_ONLY: req = low_side_only(decay_base);
        default:       req = cut_now ? gate_req_t'('0) : decay_base;
      endcase
    end
  end
endmodule

// File: rtl/srect_leg.sv
module srect_leg #(
  parameter int DEAD_CYC = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_hi,
  input  logic req_lo,
  output logic gate_hi,
  output logic gate_lo
);
  localparam int CW = $clog2(DEAD_CYC + 1);
  localparam logic [CW-1:0] GAP_LOAD = CW'(DEAD_CYC - 1);
  localparam logic [CW-1:0] RUN_MAX  = CW'(DEAD_CYC);

  logic [CW-1:0] hi_wait, lo_wait;
  logic hi_d, lo_d;

  assign hi_d = req_hi && !req_lo && (gate_hi || (!gate_lo && hi_wait == '0));
  assign lo_d = req_lo && !req_hi && (gate_lo || (!gate_hi && lo_wait == '0));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      gate_hi <= 1'b0;
      gate_lo <= 1'b0;
      hi_wait <= '0;
      lo_wait <= '0;
    end else begin
      gate_hi <= hi_d;
      gate_lo <= lo_d;
      if (gate_lo && !lo_d)   hi_wait <= GAP_LOAD;
      else if (hi_wait != '0) hi_wait <= hi_wait - CW'(1);
      if (gate_hi && !hi_d)   lo_wait <= GAP_LOAD;
      else if (lo_wait != '0) lo_wait <= lo_wait - CW'(1);
    end
  end

  // independent open-time counters for the crossover checks
  logic [CW-1:0] hi_off_run, lo_off_run;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_off_run <= RUN_MAX;
      lo_off_run <= RUN_MAX;
    end else begin
      hi_off_run <= gate_hi ? '0 : ((hi_off_run == RUN_MAX) ? RUN_MAX : hi_off_run + CW'(1));
      lo_off_run <= gate_lo ? '0 : ((lo_off_run == RUN_MAX) ? RUN_MAX : lo_off_run + CW'(1));
    end
  end

  assert_no_shoot_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !(gate_hi && gate_lo));
  assert_dead_hi_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_hi) |-> lo_off_run >= RUN_MAX);
  assert_dead_lo_R8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate_lo) |-> hi_off_run >= RUN_MAX);
endmodule

// File: rtl/srect_gate_ctrl.sv
module srect_gate_ctrl
  import srect_pkg::*;
#(
  parameter int DEAD_CYC = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] pwm_state,
  input  logic       phase,
  input  logic       bridge_en,
  input  logic [1:0] rect_mode,
  input  logic       zero_det,
  input  logic       rev_lim_det,
  output logic       src_a,
  output logic       src_b,
  output logic       snk_a,
  output logic       snk_b
);
  localparam int NUM_LEGS = 2;

  pwm_state_e state;
  rect_mode_e mode;
  logic       bridge_on;
  logic       in_decay;
  logic       cut_now;
  gate_req_t  req;
  logic [NUM_LEGS-1:0] hi_g, lo_g;

  assign state     = pwm_state_e'(pwm_state);
  assign mode      = rect_mode_e'(rect_mode);
  assign bridge_on = bridge_en && (state == PWM_ON);
  assign in_decay  = !bridge_on;

  srect_cutoff u_cutoff (
    .clk        (clk),
    .rst_n      (rst_n),
    .bridge_on  (bridge_on),
    .mode       (mode),
    .zero_det   (zero_det),
    .rev_lim_det(rev_lim_det),
    .cut_now    (cut_now)
  );

  srect_pattern u_pattern (
    .state    (state),
    .phase    (phase),
    .bridge_en(bridge_en),
    .bridge_on(bridge_on),
    .mode     (mode),
    .cut_now  (cut_now),
    .req      (req)
  );

  for (genvar g = 0; g < NUM_LEGS; g++) begin : g_leg
    srect_leg #(.DEAD_CYC(DEAD_CYC)) u_leg (
      .clk    (clk),
      .rst_n  (rst_n),
      .req_hi (req.hi[g]),
      .req_lo (req.lo[g]),
      .gate_hi(hi_g[g]),
      .gate_lo(lo_g[g])
    );
  end

  assign src_a = hi_g[0];
  assign snk_a = lo_g[0];
  assign src_b = hi_g[1];
  assign snk_b = lo_g[1];

  assert_idle_off_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_decay && mode == RECT_NONE) |-> !(src_a || src_b || snk_a || snk_b));
  assert_low_only_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $past(in_decay && mode == RECT_LOW_ONLY) |-> !(src_a || src_b));
  // covers R6 as well: any stop opens the whole bridge
  assert_cut_off_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cut_now) |-> !(src_a || src_b || snk_a || snk_b));
  assert_no_src_pair_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !(src_a && src_b));
endmodule

// File: tb/srect_gate_ctrl_tb.sv
`timescale 1ns/1ps
module srect_gate_ctrl_tb;
  typedef struct {
    logic [3:0] exp;
    string      tag;
  } sb_item_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] pwm_state = 2'd0;
  logic phase = 1'b0;
  logic bridge_en = 1'b0;
  logic [1:0] rect_mode = 2'd2;
  logic zero_det = 1'b0;
  logic rev_lim_det = 1'b0;
  logic src_a, src_b, snk_a, snk_b;
  logic [3:0] gates;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  sb_item_t sb_q[$];

  always #4 clk = ~clk;
  assign gates = {src_a, src_b, snk_a, snk_b};

  srect_gate_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .pwm_state(pwm_state), .phase(phase),
    .bridge_en(bridge_en), .rect_mode(rect_mode), .zero_det(zero_det),
    .rev_lim_det(rev_lim_det), .src_a(src_a), .src_b(src_b),
    .snk_a(snk_a), .snk_b(snk_b)
  );

  task automatic check(input logic [3:0] act, input logic [3:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%b expected=%b (src_a src_b snk_a snk_b)", tag, act, exp);
    end
  endtask

  // monitor: compares queued expectations against the outputs
  initial begin
    forever begin
      @(negedge clk);
      if (sb_q.size() > 0) begin
        sb_item_t it;
        it = sb_q.pop_front();
        check(gates, it.exp, it.tag);
      end
    end
  end

  // driver: applies inputs, waits past the crossover gap, queues the expectation
  task automatic drive(input logic [1:0] st, input logic ph, input logic en,
                       input logic [1:0] md, input logic zd, input logic rl,
                       input logic [3:0] exp, input string tag);
    sb_item_t it;
    @(negedge clk);
    pwm_state = st; phase = ph; bridge_en = en;
    rect_mode = md; zero_det = zd; rev_lim_det = rl;
    repeat (6) @(negedge clk);
    it.exp = exp;
    it.tag = tag;
    sb_q.push_back(it);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check(gates, 4'b0000, "R9 outputs low in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check(gates, 4'b0000, "R9 after release");

    // R1: from all-open state the drive pattern appears on the next edge
    pwm_state = 2'd0; phase = 1'b1; bridge_en = 1'b1; rect_mode = 2'd0;
    @(negedge clk);
    check(gates, 4'b1001, "R1 one-edge latency");

    drive(2'd0, 1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 4'b1001, "R1 drive fwd");
    drive(2'd0, 1'b0, 1'b1, 2'd0, 1'b0, 1'b0, 4'b0110, "R1 drive rev");
    drive(2'd1, 1'b0, 1'b1, 2'd1, 1'b0, 1'b0, 4'b1001, "R2 fast rev passive");
    drive(2'd0, 1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 4'b1001, "R1 drive fwd again");
    drive(2'd1, 1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 4'b0110, "R2 fast fwd active");
    drive(2'd2, 1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 4'b0011, "R3 slow decay");
    drive(2'd3, 1'b0, 1'b1, 2'd1, 1'b0, 1'b0, 4'b0011, "R3 slow alt code");
    drive(2'd0, 1'b1, 1'b0, 2'd0, 1'b0, 1'b0, 4'b0011, "R3 bridge disabled");
    drive(2'd1, 1'b1, 1'b0, 2'd1, 1'b0, 1'b0, 4'b0011, "R3 disabled overrides fast");
    drive(2'd2, 1'b1, 1'b1, 2'd2, 1'b0, 1'b0, 4'b0000, "R4 slow none");
    drive(2'd1, 1'b1, 1'b1, 2'd2, 1'b0, 1'b0, 4'b0000, "R4 fast none");
    drive(2'd1, 1'b1, 1'b1, 2'd3, 1'b0, 1'b0, 4'b0010, "R7 fast low-only");
    drive(2'd2, 1'b1, 1'b1, 2'd3, 1'b0, 1'b0, 4'b0011, "R7 slow low-only");
    drive(2'd1, 1'b1, 1'b1, 2'd3, 1'b1, 1'b1, 4'b0010, "R7 detectors ignored");
    drive(2'd1, 1'b1, 1'b1, 2'd1, 1'b1, 1'b0, 4'b0110, "R5 zero ignored in passive");
    drive(2'd1, 1'b1, 1'b1, 2'd0, 1'b0, 1'b1, 4'b0110, "R6 limit ignored in active");

    // R5 stop in active mode and its hold (R10)
    drive(2'd0, 1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 4'b1001, "R10 drive clears");
    drive(2'd1, 1'b1, 1'b1, 2'd0, 1'b1, 1'b0, 4'b0000, "R5 zero stops rectify");
    drive(2'd1, 1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 4'b0000, "R10 stop held");
    drive(2'd2, 1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 4'b0000, "R10 held into slow");
    drive(2'd0, 1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 4'b1001, "R10 drive after stop");
    drive(2'd1, 1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 4'b0110, "R10 stop cleared");
    drive(2'd0, 1'b1, 1'b1, 2'd0, 1'b1, 1'b0, 4'b1001, "R5 zero ignored in drive");
    drive(2'd1, 1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 4'b0110, "R5 no stop carried from drive");

    // R6 stop in passive mode
    drive(2'd0, 1'b0, 1'b1, 2'd1, 1'b0, 1'b1, 4'b0110, "R6 limit ignored in drive");
    drive(2'd1, 1'b0, 1'b1, 2'd1, 1'b0, 1'b0, 4'b1001, "R6 fast passive rectifies");
    drive(2'd1, 1'b0, 1'b1, 2'd1, 1'b0, 1'b1, 4'b0000, "R6 limit stops rectify");
    drive(2'd1, 1'b0, 1'b1, 2'd1, 1'b0, 1'b0, 4'b0000, "R10 limit stop held");
    drive(2'd0, 1'b0, 1'b0, 2'd1, 1'b0, 1'b0, 4'b0000, "R10 disable does not clear");
    drive(2'd0, 1'b0, 1'b1, 2'd1, 1'b0, 1'b0, 4'b0110, "R10 enabled drive clears");

    // R8 crossover gap, exact cycles
    drive(2'd0, 1'b1, 1'b1, 2'd0, 1'b0, 1'b0, 4'b1001, "R8 setup drive");
    pwm_state = 2'd1;
    @(negedge clk);
    check(gates, 4'b0000, "R8 gap cycle 1");
    @(negedge clk);
    check(gates, 4'b0000, "R8 gap cycle 2");
    @(negedge clk);
    check(gates, 4'b0110, "R8 decay pair after gap");
    pwm_state = 2'd0;
    @(negedge clk);
    check(gates, 4'b0000, "R8 back gap 1");
    @(negedge clk);
    check(gates, 4'b0000, "R8 back gap 2");
    @(negedge clk);
    check(gates, 4'b1001, "R8 drive pair after gap");

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule